// File: doc/BRIEF.md
# Single-Buffer DMA Engine

This block is a memory-mapped copy engine that owns a private 4096-byte staging buffer. Software loads four 64-bit registers: a source address, a destination address, a byte count and a command word. Writing a command with its run bit set arms the engine. After a fixed start delay it moves the requested bytes, one per handshake, either from system memory into the buffer or from the buffer out to system memory. System memory is reached through a simple valid/ready byte master port.

The buffer is seen by software as a window of addresses starting at 0x40000. On the buffer side, the window base is subtracted to get the buffer offset, and the whole range must fit inside the window. On the system side, the address is reduced by a mask, which by default keeps the low 28 bits. When the copy ends the run bit clears. If the command asked for it, a one-cycle interrupt request carrying the code 0x100 is raised. A range that fails the window test is refused. In that case the run bit clears, an error flag is set, no data moves and no interrupt is raised.

While a copy is pending or running, every register write is dropped, so software must poll the run bit before it reprograms the engine.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, all four registers read as zero, `mem_valid` is low and `irq_set` is zero.
- R2: The registers sit at byte offsets 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command).
    - An 8-byte write (`reg_size`=8) stores all 64 bits.
    - A 4-byte write stores `reg_wdata[31:0]` with the upper half zeroed.
    - Writes of any other size are ignored.
    - A read of size 8 returns the full register and a read of size 4 returns its low 32 bits, zero-extended.
    - A read of any other size, or of an unmapped offset, returns all ones.
- R3: In the command word, bit 0 is run, bit 1 is direction and bit 2 is interrupt-enable. Bits 2:0 are stored and read back, and bit 31 reads the error flag. A command write whose bit 0 is 0 is discarded and starts nothing.
- R4: While run is set, writes to all four registers are ignored.
- R5: The first memory request (`mem_valid` high) appears exactly START_DELAY clock edges after the clock edge that accepts the command write.
- R6: With direction 0, byte k is read from system address source+k and stored at buffer offset destination-0x40000+k.
- R7: With direction 1, byte k is taken from buffer offset source-0x40000+k and written to system address destination+k.
- R8: Let A be the buffer-side address and N the count. The copy runs only when A >= 0x40000, N >= 1 and A+N <= 0x41000. Otherwise, at the end of the delay, run clears, bit 31 sets, no memory request is made and no interrupt is raised.
- R9: The system address of byte k on `mem_addr` is (system-side register + k) AND SYS_MASK. Bit 31 of the command is set for an accepted copy whose system-side start address has bits outside the mask. Bit 31 is cleared by the next accepted command write.
- R10: At completion, run clears. If bit 2 was set, `irq_set` equals 0x100 for exactly one cycle, the cycle after the last handshake; otherwise it stays zero.
- R11: One byte moves per cycle in which `mem_valid` and `mem_ready` are both high, for exactly the count. While `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write to system memory, 0 = read |
| mem_addr | output | SYS_AW | Masked system byte address |
| mem_wdata | output | 8 | Byte written to system memory |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ready` |
| irq_set | output | 32 | Completion interrupt request pulse |

## Verification
A wrong buffer offset or a wrong direction decode first shows up as wrong bytes on `mem_wdata`. That happens only during the later outbound copy from the same window, so each inbound sweep is paired with an outbound copy, and every written byte is compared against an arithmetic model. A faulty address step or mask shows on `mem_addr` at the first handshake. A faulty timer or window test shows within START_DELAY cycles of the command: as a misplaced first request, or as a request that should never have appeared. A lost lock or a stale end condition shows as a wrong handshake count or as register read-back after completion.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam logic [7:0] OFS_SRC = 8'h80;
    localparam logic [7:0] OFS_DST = 8'h88;
    localparam logic [7:0] OFS_CNT = 8'h90;
    localparam logic [7:0] OFS_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IEN = 2;
    localparam int CMD_ERR = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2
    } xfer_state_e;

    function automatic logic size_ok(input logic [3:0] sz);
        return (sz == 4'd4) || (sz == 4'd8);
    endfunction

    function automatic logic [63:0] size_fit(input logic [3:0] sz, input logic [63:0] v);
        return (sz == 4'd8) ? v : {32'h0, v[31:0]};
    endfunction

endpackage

// File: rtl/dma_start_timer.sv
module dma_start_timer #(
    parameter int DELAY = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d  = tmr_q;
        expire = tmr_q.busy && (tmr_q.cnt == CW'(DELAY - 1));
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end else if (expire) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assert_expire_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !expire);

    assert_start_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> tmr_q.busy);

endmodule

// File: rtl/dma_window_check.sv
module dma_window_check #(
    parameter logic [63:0] BASE  = 64'h4_0000,
    parameter int          SIZE  = 4096,
    parameter int          OFF_W = 12
) (
    input  logic [63:0]      addr,
    input  logic [63:0]      len,
    output logic             ok,
    output logic [OFF_W-1:0] off
);
    localparam logic [63:0] LIMIT = BASE + 64'(SIZE);

    logic        above_lo;
    logic        below_hi;
    logic [63:0] room;
    logic [63:0] rel;

    always_comb begin
        above_lo = (addr >= BASE);
        below_hi = (addr < LIMIT);
        room     = LIMIT - addr;
        rel      = addr - BASE;
        ok       = above_lo && below_hi && (len != 64'h0) && (len <= room);
        off      = rel[OFF_W-1:0];
    end

endmodule

// File: rtl/dma_byte_store.sv
module dma_byte_store #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter logic [63:0] BUF_BASE    = 64'h4_0000,
    parameter int          BUF_BYTES   = 4096,
    parameter int          START_DELAY = 100,
    parameter int          SYS_AW      = 32,
    parameter logic [SYS_AW-1:0] SYS_MASK = SYS_AW'(32'h0FFF_FFFF),
    parameter logic [31:0] IRQ_DONE    = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [SYS_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    output logic [31:0]       irq_set
);
    localparam int OFF_W = $clog2(BUF_BYTES);
    localparam int IDX_W = $clog2(BUF_BYTES + 1);

    typedef struct packed {
        logic [63:0]      src;
        logic [63:0]      dst;
        logic [63:0]      cnt;
        logic [2:0]       cmd;
        logic             err;
        xfer_state_e      st;
        logic [IDX_W-1:0] idx;
        logic             irq;
    } eng_t;

    eng_t state_q, state_d;

    logic             wr_ok;
    logic [63:0]      wr_val;
    logic             tmr_start;
    logic             tmr_expire;
    logic [63:0]      buf_side;
    logic [63:0]      sys_side;
    logic             win_ok;
    logic [OFF_W-1:0] win_off;
    logic [OFF_W-1:0] buf_idx;
    logic             buf_we;
    logic [7:0]       buf_rdata;
    logic             mask_err;
    logic [IDX_W-1:0] idx_next;
    logic [63:0]      cmd_view;
    logic [63:0]      rd_raw;
    logic             rd_hit;

    // Side selection: direction picks which register addresses the buffer window
    assign buf_side = state_q.cmd[CMD_DIR] ? state_q.src : state_q.dst;
    assign sys_side = state_q.cmd[CMD_DIR] ? state_q.dst : state_q.src;
    assign mask_err = (|sys_side[63:SYS_AW]) || (|(sys_side[SYS_AW-1:0] & ~SYS_MASK));
    assign buf_idx  = win_off + OFF_W'(state_q.idx);
    assign idx_next = state_q.idx + 1'b1;

    dma_window_check #(
        .BASE (BUF_BASE),
        .SIZE (BUF_BYTES),
        .OFF_W(OFF_W)
    ) u_window (
        .addr(buf_side),
        .len (state_q.cnt),
        .ok  (win_ok),
        .off (win_off)
    );

    dma_start_timer #(
        .DELAY(START_DELAY)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .expire(tmr_expire)
    );

    dma_byte_store #(
        .DEPTH(BUF_BYTES),
        .AW   (OFF_W)
    ) u_store (
        .clk  (clk),
        .we   (buf_we),
        .waddr(buf_idx),
        .wdata(mem_rdata),
        .raddr(buf_idx),
        .rdata(buf_rdata)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        state_d.irq = 1'b0;
        tmr_start = 1'b0;
        buf_we    = 1'b0;
        wr_ok     = reg_wr && !state_q.cmd[CMD_RUN] && size_ok(reg_size);
        wr_val    = size_fit(reg_size, reg_wdata);

        if (wr_ok) begin
            case (reg_addr)
                OFS_SRC: state_d.src = wr_val;
                OFS_DST: state_d.dst = wr_val;
                OFS_CNT: state_d.cnt = wr_val;
                OFS_CMD: begin
                    if (wr_val[CMD_RUN]) begin
                        state_d.cmd = wr_val[2:0];
                        state_d.err = 1'b0;
                        state_d.st  = ST_WAIT;
                        state_d.idx = '0;
                        tmr_start   = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        case (state_q.st)
            ST_WAIT: begin
                if (tmr_expire) begin
                    if (!win_ok) begin
                        state_d.cmd[CMD_RUN] = 1'b0;
                        state_d.err          = 1'b1;
                        state_d.st           = ST_IDLE;
                    end else begin
                        state_d.err = mask_err;
                        state_d.st  = ST_MOVE;
                        state_d.idx = '0;
                    end
                end
            end
            ST_MOVE: begin
                if (mem_ready) begin
                    buf_we      = !state_q.cmd[CMD_DIR];
                    state_d.idx = idx_next;
                    if (idx_next == state_q.cnt[IDX_W-1:0]) begin
                        state_d.cmd[CMD_RUN] = 1'b0;
                        state_d.st           = ST_IDLE;
                        state_d.irq          = state_q.cmd[CMD_IEN];
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Master port and interrupt
    assign mem_valid = (state_q.st == ST_MOVE);
    assign mem_write = state_q.cmd[CMD_DIR];
    assign mem_addr  = (sys_side[SYS_AW-1:0] + SYS_AW'(state_q.idx)) & SYS_MASK;
    assign mem_wdata = buf_rdata;
    assign irq_set   = state_q.irq ? IRQ_DONE : 32'h0;

    // Register read mux
    always_comb begin
        cmd_view          = 64'(state_q.cmd);
        cmd_view[CMD_ERR] = state_q.err;
        rd_hit            = 1'b1;
        case (reg_addr)
            OFS_SRC: rd_raw = state_q.src;
            OFS_DST: rd_raw = state_q.dst;
            OFS_CNT: rd_raw = state_q.cnt;
            OFS_CMD: rd_raw = cmd_view;
            default: begin
                rd_raw = '1;
                rd_hit = 1'b0;
            end
        endcase
        if (!rd_hit || !size_ok(reg_size)) reg_rdata = '1;
        else                               reg_rdata = size_fit(reg_size, rd_raw);
    end

    assert_regs_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cmd[CMD_RUN] |=> ($stable(state_q.src) && $stable(state_q.dst) && $stable(state_q.cnt)));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != 32'h0) |=> (irq_set == 32'h0));

    assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != 32'h0) |-> (state_q.cmd[CMD_IEN] && !state_q.cmd[CMD_RUN]));

    assert_refuse_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_WAIT && tmr_expire && !win_ok) |=> (!mem_valid && state_q.err && !state_q.cmd[CMD_RUN]));

    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.cmd[CMD_RUN]) |-> !mem_valid);

endmodule

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
    localparam int          DLY  = 3;
    localparam logic [63:0] BASE = 64'h4_0000;
    localparam logic [7:0]  A_SRC = 8'h80, A_DST = 8'h88, A_CNT = 8'h90, A_CMD = 8'h98;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = 64'h0;
    logic [63:0] reg_rdata;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic [31:0] irq_set;

    always #2 clk = ~clk;

    dma_xfer_engine #(.START_DELAY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .irq_set(irq_set));

    int errs = 0, checks = 0;
    int hs, irqs, addr_bad, data_bad, cyc = 0;
    logic [31:0] exp_sys;
    int exp_off;
    logic exp_wr;
    logic stall = 1'b0;
    logic [7:0] salt = 8'h00;
    logic [7:0] bmodel [4096];
    logic done = 1'b0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ salt;
    endfunction

    assign mem_rdata = pat(mem_addr);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_valid && mem_ready) begin
            if (mem_addr !== exp_sys + 32'(hs)) addr_bad = addr_bad + 1;
            if (mem_write !== exp_wr) addr_bad = addr_bad + 1;
            if (mem_write && mem_wdata !== bmodel[(exp_off + hs) % 4096]) data_bad = data_bad + 1;
            hs = hs + 1;
        end
        if (irq_set == 32'h100) irqs = irqs + 1;
        else if (irq_set != 32'h0) irqs = irqs + 1000;
    end

    always @(negedge clk) mem_ready <= stall ? (cyc % 3 != 1) : 1'b1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errs = errs + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] v);
        @(negedge clk);
        reg_addr = a; reg_size = sz; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a; reg_size = sz; reg_wr = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        int guard = 0;
        do begin
            rd(A_CMD, 4'd8, v);
            guard++;
        end while (v[0] && guard < 20000);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c,
                       input logic [2:0] cmdv, input logic [31:0] esys, input int eoff,
                       input logic okx, input logic errx, input string tag);
        logic [63:0] v;
        int k = 0;
        hs = 0; irqs = 0; addr_bad = 0; data_bad = 0;
        exp_sys = esys; exp_off = eoff; exp_wr = cmdv[1];
        wr(A_SRC, 4'd8, s);
        wr(A_DST, 4'd8, d);
        wr(A_CNT, 4'd8, c);
        wr(A_CMD, 4'd4, 64'(cmdv));
        while (!mem_valid && k < DLY + 20) begin
            @(negedge clk);
            k++;
        end
        if (okx) check({tag, " R5 start delay"}, 64'(k), 64'(DLY));
        wait_idle();
        check({tag, " R11 R8 byte count"}, 64'(hs), okx ? c : 64'h0);
        check({tag, " R10 interrupt count"}, 64'(irqs), 64'((okx && cmdv[2]) ? 1 : 0));
        check({tag, " R9 address sequence"}, 64'(addr_bad), 64'h0);
        check({tag, " R6,R7 data"}, 64'(data_bad), 64'h0);
        rd(A_CMD, 4'd8, v);
        check({tag, " R3 R8 R9 command view"}, v, (errx ? 64'h8000_0000 : 64'h0) | 64'(cmdv & 3'b110));
    endtask

    int offs [6] = '{0, 5, 4095, 100, 4000, 0};
    int cnts [6] = '{1, 2, 1, 33, 96, 4096};

    initial begin
        logic [63:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_SRC, 4'd8, v); check("R1 src reset", v, 64'h0);
        rd(A_DST, 4'd8, v); check("R1 dst reset", v, 64'h0);
        rd(A_CNT, 4'd8, v); check("R1 cnt reset", v, 64'h0);
        rd(A_CMD, 4'd8, v); check("R1 cmd reset", v, 64'h0);
        check("R1 no request", 64'(mem_valid), 64'h0);
        check("R1 no irq", 64'(irq_set), 64'h0);

        // R2 access sizes
        wr(A_SRC, 4'd8, 64'h1122_3344_5566_7788);
        rd(A_SRC, 4'd8, v); check("R2 8-byte write", v, 64'h1122_3344_5566_7788);
        rd(A_SRC, 4'd4, v); check("R2 4-byte read", v, 64'h5566_7788);
        wr(A_DST, 4'd4, 64'hAABB_CCDD_9988_7766);
        rd(A_DST, 4'd8, v); check("R2 4-byte write zero-extends", v, 64'h9988_7766);
        wr(A_DST, 4'd2, 64'h1234);
        rd(A_DST, 4'd8, v); check("R2 bad-size write ignored", v, 64'h9988_7766);
        rd(A_DST, 4'd1, v); check("R2 bad-size read", v, '1);
        rd(8'h84, 4'd8, v); check("R2 unmapped read", v, '1);

        // R6 R7 sweep: inbound then outbound through the same window range
        for (int i = 0; i < 6; i++) begin
            logic [31:0] s;
            salt = 8'(i * 29 + 3);
            stall = (i % 2 == 1);
            s = 32'h2000 + 32'(i * 64);
            run(64'(s), BASE + 64'(offs[i]), 64'(cnts[i]), 3'b101, s, offs[i], 1'b1, 1'b0, "R6 in");
            for (int k = 0; k < cnts[i]; k++) bmodel[offs[i] + k] = pat(s + 32'(k));
            run(BASE + 64'(offs[i]), 64'h8000 + 64'(i), 64'(cnts[i]), 3'b111,
                32'h8000 + 32'(i), offs[i], 1'b1, 1'b0, "R7 out");
        end
        stall = 1'b0;

        // R8 refused ranges
        run(64'h100, BASE - 64'h1, 64'h1, 3'b101, 32'h100, 0, 1'b0, 1'b1, "R8 below window");
        run(64'h100, BASE + 64'd4090, 64'h7, 3'b101, 32'h100, 0, 1'b0, 1'b1, "R8 past end");
        run(64'h100, BASE, 64'h0, 3'b101, 32'h100, 0, 1'b0, 1'b1, "R8 zero count");
        run(BASE + 64'd4096, 64'h100, 64'h1, 3'b111, 32'h100, 0, 1'b0, 1'b1, "R8 out above");
        run(64'h100, BASE + 64'd10, 64'h1_0000_0000, 3'b101, 32'h100, 0, 1'b0, 1'b1, "R8 huge count");

        // R9 address mask
        salt = 8'h5A;
        run(64'h1_0000_0300, BASE + 64'd10, 64'h4, 3'b101, 32'h300, 10, 1'b1, 1'b1, "R9 mask in");
        for (int k = 0; k < 4; k++) bmodel[10 + k] = pat(32'h300 + 32'(k));
        run(BASE + 64'd10, 64'hF000_9000, 64'h4, 3'b111, 32'h9000, 10, 1'b1, 1'b1, "R9 mask out");

        // R10 no interrupt without enable
        run(64'h400, BASE + 64'd50, 64'h6, 3'b001, 32'h400, 50, 1'b1, 1'b0, "R10 no enable");
        for (int k = 0; k < 6; k++) bmodel[50 + k] = pat(32'h400 + 32'(k));

        // R4 lock while running
        hs = 0; irqs = 0; addr_bad = 0; data_bad = 0;
        exp_sys = 32'h5000; exp_off = 200; exp_wr = 1'b0;
        wr(A_SRC, 4'd8, 64'h5000);
        wr(A_DST, 4'd8, BASE + 64'd200);
        wr(A_CNT, 4'd8, 64'd64);
        wr(A_CMD, 4'd8, 64'h1);
        wr(A_SRC, 4'd8, 64'hDEAD);
        wr(A_CNT, 4'd4, 64'h5);
        wr(A_CMD, 4'd8, 64'h7);
        wait_idle();
        rd(A_SRC, 4'd8, v); check("R4 src locked", v, 64'h5000);
        rd(A_CNT, 4'd8, v); check("R4 cnt locked", v, 64'd64);
        rd(A_CMD, 4'd8, v); check("R4 cmd locked", v, 64'h0);
        check("R4 full count moved", 64'(hs), 64'd64);
        check("R4 address sequence", 64'(addr_bad), 64'h0);

        // R3 command without run bit discarded
        hs = 0;
        wr(A_CMD, 4'd4, 64'h6);
        repeat (DLY + 8) @(negedge clk);
        rd(A_CMD, 4'd8, v); check("R3 no-run command dropped", v, 64'h0);
        check("R3 no request started", 64'(hs), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errs = errs + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule